// File: doc/BRIEF.md
# Synchronous CPU to Handshake Backplane Bridge

This block links an 8-bit processor bus, which advances on a slow phase clock (phi2), to a backplane on which every transfer is paced by strobes and acknowledges with no common clock. The bridge runs on its own fast clock. Every control input from either side passes through a synchronizer before the sequencer acts on it. The backplane has a 20-bit address, an 8-bit data bus and a 3-bit command field. Each backplane bus is presented as a value plus its own output enable.

Writes are posted. The bridge captures the CPU address, command and data while phi2 is high. It keeps the CPU ready line asserted, so the processor continues at once. The bridge then completes the transfer on the backplane. Only a second access made while that transfer is still open meets a negated ready line.

Reads work differently. The bridge drops ready as soon as it sees the request and fetches the byte over the backplane. It waits for the responder to withdraw its reply. It then returns the byte during a phi2-high phase, and it restores ready only for that phase.

Top module: `async_bus_bridge`

## Requirements
- R1: After reset, cpu_ready is 1, cpu_rdata_oe is 0, every backplane output enable is 0 and both active-low strobes are 1.
- R2: While idle, a phi2-high phase without cpu_sel starts no backplane cycle. No enable rises, no strobe falls, and cpu_ready stays 1.
- R3: A write (phi2 high, cpu_sel 1, cpu_rnw 0) keeps cpu_ready at 1 for the whole phi2-high phase. The bridge drives the address and data that were present when phi2 fell, and the command {1, cpu_addr[20], cpu_rnw}. Command bit 0 is R/W, bit 1 is address bit 20 (memory or I/O space) and bit 2 is constant 1.
- R4: A write enters a single clock in which address, command and data are enabled with both strobes still 1. Both strobes fall on the next clock. cpu_ready is 0 from that drive clock until the write has fully ended.
- R5: Once low, the strobes stay low for as long as neither the acknowledge nor the error input is asserted (both active low).
- R6: Either the acknowledge or the error input ends the cycle. Both strobes return to 1, and all backplane enables drop in the same clock. The bridge does not go idle, or raise cpu_ready after a write, until both inputs are negated.
- R7: A read (phi2 high, cpu_sel 1, cpu_rnw 1) drops cpu_ready within 4 clocks. It drives the captured address and the command {1, cpu_addr[20], 1} while the strobes are low, and it never enables the backplane data bus.
- R8: The byte returned to the CPU is the backplane data present in the last clocks of the strobe phase. Earlier values and later changes do not affect it.
- R9: The returned byte is driven (cpu_rdata_oe 1) together with cpu_ready 1 only while phi2 is high. If phi2 is low when the reply is withdrawn, the bridge waits for phi2 to rise. When phi2 falls, cpu_rdata_oe drops and the bridge is idle.
- R10: The bridge does not accept a request made while a transfer is open. The CPU sees cpu_ready at 0, and the request starts no backplane cycle after the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock, much faster than phi2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_phi2 | input | 1 | CPU phase clock (asynchronous) |
| cpu_sel | input | 1 | Backplane space selected by the CPU address (asynchronous) |
| cpu_rnw | input | 1 | 1 for read, 0 for write |
| cpu_addr | input | 21 | CPU address; the top bit picks memory or I/O space |
| cpu_wdata | input | 8 | CPU write data |
| cpu_ready | output | 1 | Ready to the CPU |
| cpu_rdata | output | 8 | Returned read byte |
| cpu_rdata_oe | output | 1 | Enable for cpu_rdata onto the CPU data bus |
| bp_addr | output | 20 | Backplane address value |
| bp_addr_oe | output | 1 | Backplane address enable |
| bp_cmd | output | 3 | Backplane command value |
| bp_cmd_oe | output | 1 | Backplane command enable |
| bp_wdata | output | 8 | Backplane write data value |
| bp_wdata_oe | output | 1 | Backplane data enable |
| bp_rdata | input | 8 | Backplane data as seen on the bus |
| bp_astb_n | output | 1 | Address strobe, active low |
| bp_dstb_n | output | 1 | Data strobe, active low |
| bp_ack_n | input | 1 | Data acknowledge, active low (asynchronous) |
| bp_err_n | input | 1 | Transfer error, active low (asynchronous) |

## Verification
A sequencer stuck in a wait state shows at the ports within a few bridge clocks. The strobes stay low after the reply, or cpu_ready never returns, so polling with a bound reports it on the same transaction. A wrong capture edge shows as a backplane address, command or data value that follows the CPU inputs once the bench has changed them. A read exit taken on the wrong phi2 level shows as cpu_rdata_oe high while phi2 is low, or as ready returning early. In either case the error appears within the synchronizer latency of the phi2 edge.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

   localparam int unsigned BR_CMD_W = 3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WCAP,
      ST_WDRV,
      ST_WSTB,
      ST_WREL,
      ST_RCAP,
      ST_RSTB,
      ST_RREL,
      ST_RWAIT,
      ST_RDONE
   } br_state_e;

   typedef struct packed {
      logic ready;
      logic capture;
      logic drv_addr;
      logic drv_data;
      logic strobe;
      logic rd_load;
      logic cpu_drive;
   } br_ctl_t;

   function automatic br_ctl_t br_decode(input br_state_e s);
      br_ctl_t c;
      c = '0;
      case (s)
         ST_IDLE:  c.ready = 1'b1;
         ST_WCAP:  begin c.ready = 1'b1; c.capture = 1'b1; end
         ST_WDRV:  begin c.drv_addr = 1'b1; c.drv_data = 1'b1; end
         ST_WSTB:  begin c.drv_addr = 1'b1; c.drv_data = 1'b1; c.strobe = 1'b1; end
         ST_RCAP:  c.capture = 1'b1;
         ST_RSTB:  begin c.drv_addr = 1'b1; c.strobe = 1'b1; c.rd_load = 1'b1; end
         ST_RDONE: begin c.ready = 1'b1; c.cpu_drive = 1'b1; end
         default:  c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/br_sync.sv
module br_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("br_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("br_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d};
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/br_fsm.sv
module br_fsm
   import bridge_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    phi2_s,
   input  logic    sel_s,
   input  logic    rnw,
   input  logic    resp_s,
   output br_ctl_t ctl
);

   br_state_e state_q, state_d;
   br_ctl_t   ctl_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (phi2_s && sel_s) state_d = rnw ? ST_RCAP : ST_WCAP;
         ST_WCAP:  if (!phi2_s) state_d = ST_WDRV;
         ST_WDRV:  state_d = ST_WSTB;
         ST_WSTB:  if (resp_s) state_d = ST_WREL;
         ST_WREL:  if (!resp_s) state_d = ST_IDLE;
         ST_RCAP:  state_d = ST_RSTB;
         ST_RSTB:  if (resp_s) state_d = ST_RREL;
         ST_RREL:  if (!resp_s) state_d = phi2_s ? ST_RDONE : ST_RWAIT;
         ST_RWAIT: if (phi2_s) state_d = ST_RDONE;
         ST_RDONE: if (!phi2_s) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   // control outputs are registered from the next state so they leave flops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ctl_q   <= br_decode(ST_IDLE);
      end else begin
         state_q <= state_d;
         ctl_q   <= br_decode(state_d);
      end
   end

   assign ctl = ctl_q;

   // R10
   start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q.capture) |-> $past(state_q) == ST_IDLE);

   // R7
   read_no_wdrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RSTB) |-> !ctl_q.drv_data);

endmodule

// File: rtl/br_datapath.sv
module br_datapath
   import bridge_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  br_ctl_t             ctl,
   input  logic [ADDR_W:0]     cpu_addr,
   input  logic                cpu_rnw,
   input  logic [DATA_W-1:0]   cpu_wdata,
   input  logic [DATA_W-1:0]   bp_rdata,
   output logic [ADDR_W-1:0]   addr_q,
   output logic [BR_CMD_W-1:0] cmd_q,
   output logic [DATA_W-1:0]   wdata_q,
   output logic [DATA_W-1:0]   rdata_q
);

   if (BR_CMD_W != 3) begin : g_bad_cmd
      $error("br_datapath: command field layout needs 3 bits");
   end

   // bit2 fixed 1, bit1 space select, bit0 direction
   logic [BR_CMD_W-1:0] cmd_next;
   assign cmd_next = {1'b1, cpu_addr[ADDR_W], cpu_rnw};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cmd_q   <= '0;
         wdata_q <= '0;
      end else if (ctl.capture) begin
         addr_q  <= cpu_addr[ADDR_W-1:0];
         cmd_q   <= cmd_next;
         wdata_q <= cpu_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (ctl.rd_load) begin
         rdata_q <= bp_rdata;
      end
   end

endmodule

// File: rtl/async_bus_bridge.sv
module async_bus_bridge
   import bridge_pkg::*;
#(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_phi2,
   input  logic                cpu_sel,
   input  logic                cpu_rnw,
   input  logic [ADDR_W:0]     cpu_addr,
   input  logic [DATA_W-1:0]   cpu_wdata,
   output logic                cpu_ready,
   output logic [DATA_W-1:0]   cpu_rdata,
   output logic                cpu_rdata_oe,
   output logic [ADDR_W-1:0]   bp_addr,
   output logic                bp_addr_oe,
   output logic [BR_CMD_W-1:0] bp_cmd,
   output logic                bp_cmd_oe,
   output logic [DATA_W-1:0]   bp_wdata,
   output logic                bp_wdata_oe,
   input  logic [DATA_W-1:0]   bp_rdata,
   output logic                bp_astb_n,
   output logic                bp_dstb_n,
   input  logic                bp_ack_n,
   input  logic                bp_err_n
);

   localparam int unsigned N_ASYNC = 4;

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("async_bus_bridge: widths must be positive");
   end

   logic [N_ASYNC-1:0] async_raw, async_s;
   logic phi2_s, sel_s, ack_s, err_s, resp_s;
   br_ctl_t ctl;

   assign async_raw = {~bp_err_n, ~bp_ack_n, cpu_sel, cpu_phi2};

   br_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (async_raw),
      .q     (async_s)
   );

   assign {err_s, ack_s, sel_s, phi2_s} = async_s;
   assign resp_s = ack_s | err_s;

   br_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .phi2_s (phi2_s),
      .sel_s  (sel_s),
      .rnw    (cpu_rnw),
      .resp_s (resp_s),
      .ctl    (ctl)
   );

   br_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .cpu_addr  (cpu_addr),
      .cpu_rnw   (cpu_rnw),
      .cpu_wdata (cpu_wdata),
      .bp_rdata  (bp_rdata),
      .addr_q    (bp_addr),
      .cmd_q     (bp_cmd),
      .wdata_q   (bp_wdata),
      .rdata_q   (cpu_rdata)
   );

   assign cpu_ready    = ctl.ready;
   assign cpu_rdata_oe = ctl.cpu_drive;
   assign bp_addr_oe   = ctl.drv_addr;
   assign bp_cmd_oe    = ctl.drv_addr;
   assign bp_wdata_oe  = ctl.drv_data;
   assign bp_astb_n    = ~ctl.strobe;
   assign bp_dstb_n    = ~ctl.strobe;

   // R4
   setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bp_astb_n) && bp_wdata_oe) |-> ($past(bp_addr_oe) && $past(bp_wdata_oe)));

   // R5
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bp_astb_n && !resp_s) |=> !bp_astb_n);

   // R6
   release_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bp_astb_n) |-> (!bp_addr_oe && !bp_cmd_oe && !bp_wdata_oe));

   // R6
   ready_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_ready) && !cpu_rdata_oe) |-> !$past(resp_s));

   // R9
   rdata_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rdata_oe && !phi2_s) |=> !cpu_rdata_oe);

   // R9
   rdata_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rdata_oe) |-> $past(phi2_s));

   // R7
   bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_rdata_oe, bp_wdata_oe}));

endmodule

// File: tb/test_async_bus_bridge.sv
module test_async_bus_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_phi2 = 1'b0;
   logic        cpu_sel = 1'b0;
   logic        cpu_rnw = 1'b0;
   logic [20:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_ready;
   logic [7:0]  cpu_rdata;
   logic        cpu_rdata_oe;
   logic [19:0] bp_addr;
   logic        bp_addr_oe;
   logic [2:0]  bp_cmd;
   logic        bp_cmd_oe;
   logic [7:0]  bp_wdata;
   logic        bp_wdata_oe;
   logic [7:0]  bp_rdata = '0;
   logic        bp_astb_n;
   logic        bp_dstb_n;
   logic        bp_ack_n = 1'b1;
   logic        bp_err_n = 1'b1;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   async_bus_bridge i_async_bus_bridge (
      .clk(clk), .rst_n(rst_n), .cpu_phi2(cpu_phi2), .cpu_sel(cpu_sel),
      .cpu_rnw(cpu_rnw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
      .bp_addr(bp_addr), .bp_addr_oe(bp_addr_oe), .bp_cmd(bp_cmd),
      .bp_cmd_oe(bp_cmd_oe), .bp_wdata(bp_wdata), .bp_wdata_oe(bp_wdata_oe),
      .bp_rdata(bp_rdata), .bp_astb_n(bp_astb_n), .bp_dstb_n(bp_dstb_n),
      .bp_ack_n(bp_ack_n), .bp_err_n(bp_err_n)
   );

   typedef struct packed {
      logic        rnw;
      logic        err;
      logic        early;
      logic        intrude;
      logic [20:0] addr;
      logic [7:0]  data;
   } vec_t;

   localparam int N_VEC = 6;
   localparam vec_t VECS [N_VEC] = '{
      '{1'b0, 1'b0, 1'b0, 1'b0, 21'h0_1234, 8'hA5},
      '{1'b0, 1'b1, 1'b0, 1'b0, 21'h1_F00D, 8'h3C},
      '{1'b1, 1'b0, 1'b0, 1'b0, 21'h0_0042, 8'h5A},
      '{1'b1, 1'b1, 1'b1, 1'b0, 21'h1_ABCD, 8'hC3},
      '{1'b0, 1'b0, 1'b0, 1'b1, 21'h1_FFFF, 8'hFF},
      '{1'b1, 1'b0, 1'b1, 1'b0, 21'h0_0000, 8'h00}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_astb(input logic lvl, input string req);
      int n = 0;
      while (bp_astb_n !== lvl && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk_eq(req, bp_astb_n, lvl);
   endtask

   task automatic wait_ready(input logic lvl, input string req, output int cyc);
      cyc = 0;
      while (cpu_ready !== lvl && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      chk_eq(req, cpu_ready, lvl);
   endtask

   task automatic respond(input logic err);
      bp_ack_n = 1'b0;
      if (err) bp_err_n = 1'b0;
   endtask

   task automatic release_resp(input logic err);
      tick(4);
      chk_eq("R6 ready withheld while reply held", cpu_ready, 1'b0);
      bp_ack_n = 1'b1;
      if (err) begin
         tick(5);
         chk_eq("R6 ready withheld while error held", cpu_ready, 1'b0);
         bp_err_n = 1'b1;
      end
   endtask

   task automatic do_write(input vec_t v);
      int n;
      int cyc;
      int seen;
      cpu_addr = v.addr; cpu_rnw = 1'b0; cpu_wdata = v.data;
      cpu_sel = 1'b1; cpu_phi2 = 1'b1;
      tick(8);
      chk_eq("R3 ready kept during posted write", cpu_ready, 1'b1);
      cpu_phi2 = 1'b0;
      n = 0;
      while (bp_wdata_oe !== 1'b1 && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk_eq("R4 drive clock reached", bp_wdata_oe, 1'b1);
      chk_eq("R4 strobes high in drive clock", bp_astb_n, 1'b1);
      cpu_addr = ~v.addr; cpu_wdata = ~v.data; cpu_sel = 1'b0;
      tick(1);
      chk_eq("R4 strobes fall after one drive clock", {bp_astb_n, bp_dstb_n}, 2'b00);
      chk_eq("R3 address", bp_addr, v.addr[19:0]);
      chk_eq("R3 command", bp_cmd, {1'b1, v.addr[20], 1'b0});
      chk_eq("R3 data", bp_wdata, v.data);
      chk_eq("R3 enables", {bp_addr_oe, bp_cmd_oe, bp_wdata_oe}, 3'b111);
      chk_eq("R4 ready negated while busy", cpu_ready, 1'b0);
      if (v.intrude) begin
         cpu_rnw = 1'b1; cpu_sel = 1'b1; cpu_phi2 = 1'b1;
         tick(6);
         chk_eq("R10 request during busy stalled", cpu_ready, 1'b0);
         cpu_phi2 = 1'b0; cpu_sel = 1'b0; cpu_rnw = 1'b0;
         tick(3);
      end else begin
         tick(4);
      end
      chk_eq("R5 strobes held without reply", bp_astb_n, 1'b0);
      respond(v.err);
      wait_astb(1'b1, "R6 strobe ends on reply");
      chk_eq("R6 buses released", {bp_addr_oe, bp_cmd_oe, bp_wdata_oe, bp_dstb_n}, 4'b0001);
      release_resp(v.err);
      wait_ready(1'b1, "R6 ready after release", cyc);
      if (v.intrude) begin
         seen = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bp_astb_n !== 1'b1 || bp_addr_oe !== 1'b0) seen++;
         end
         chk_eq("R10 no cycle from refused request", seen, 0);
      end
   endtask

   task automatic do_read(input vec_t v);
      int cyc;
      cpu_addr = v.addr; cpu_rnw = 1'b1; cpu_sel = 1'b1; cpu_phi2 = 1'b1;
      bp_rdata = ~v.data;
      wait_ready(1'b0, "R7 ready dropped", cyc);
      chk_eq("R7 ready drop latency", (cyc <= 4), 1'b1);
      tick(1);
      cpu_addr = ~v.addr;
      wait_astb(1'b0, "R7 read strobe");
      chk_eq("R7 read address", bp_addr, v.addr[19:0]);
      chk_eq("R7 read command", bp_cmd, {1'b1, v.addr[20], 1'b1});
      chk_eq("R7 read enables", {bp_addr_oe, bp_cmd_oe, bp_wdata_oe, bp_dstb_n}, 4'b1100);
      tick(2);
      bp_rdata = v.data;
      tick(2);
      cpu_phi2 = 1'b0;
      respond(v.err);
      wait_astb(1'b1, "R6 read strobe ends");
      bp_rdata = v.data ^ 8'h5A;
      chk_eq("R6 read buses released", {bp_addr_oe, bp_cmd_oe}, 2'b00);
      if (v.early) cpu_phi2 = 1'b1;
      release_resp(v.err);
      if (!v.early) begin
         tick(8);
         chk_eq("R9 waits for phi2 high", {cpu_ready, cpu_rdata_oe}, 2'b00);
         cpu_phi2 = 1'b1;
      end
      wait_ready(1'b1, "R9 ready on return", cyc);
      chk_eq("R9 data driven to CPU", cpu_rdata_oe, 1'b1);
      chk_eq("R8 returned byte", cpu_rdata, v.data);
      tick(3);
      chk_eq("R9 data held while phi2 high", {cpu_rdata_oe, cpu_rdata}, {1'b1, v.data});
      cpu_phi2 = 1'b0; cpu_sel = 1'b0;
      tick(5);
      chk_eq("R9 idle after phi2 falls", {cpu_rdata_oe, cpu_ready}, 2'b01);
   endtask

   initial begin
      int seen;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      chk_eq("R1 reset ready/rdata_oe", {cpu_ready, cpu_rdata_oe}, 2'b10);
      chk_eq("R1 reset enables", {bp_addr_oe, bp_cmd_oe, bp_wdata_oe}, 3'b000);
      chk_eq("R1 reset strobes", {bp_astb_n, bp_dstb_n}, 2'b11);

      // R2 phi2 high without select
      cpu_phi2 = 1'b1; cpu_sel = 1'b0; cpu_rnw = 1'b0;
      seen = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (bp_addr_oe !== 1'b0 || bp_astb_n !== 1'b1 || cpu_ready !== 1'b1) seen++;
      end
      chk_eq("R2 no cycle without select", seen, 0);
      cpu_phi2 = 1'b0;
      tick(4);

      for (int k = 0; k < N_VEC; k++) begin
         if (VECS[k].rnw) do_read(VECS[k]);
         else do_write(VECS[k]);
         tick(3);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule